// File: doc/BRIEF.md
# Synchronous Burst Read Engine for External NOR Flash

This block performs synchronous burst reads from an external NOR flash. A request carries a start address and a word count. On acceptance the engine selects the memory, drives the address, and starts a memory clock derived from the system clock at a programmable divide ratio. An active-low address-valid strobe marks the first memory clock period.

Once the address is latched, the engine counts a programmable initial latency in memory clock edges. It then gathers one 16-bit word per memory clock rising edge. An edge is skipped when the memory raises its wait input. Each gathered word leaves the block as a one-cycle data-valid pulse.

After the last word, the engine parks the memory clock low, deselects the memory and gives a one-cycle done pulse. Divide ratio and latency are sampled with each request, so every burst can use its own timing.

Top module: `nor_burst_reader`

## Requirements
- R1: `req_ready` is high exactly when no burst is running. A request is taken on a rising clock edge with `req_valid` and `req_ready` both high. `req_addr`, `req_len_m1`, `cfg_div_m1` and `cfg_lat_m2` are sampled at that edge.
- R2: The memory clock period is R system cycles, where R = `cfg_div_m1` + 1. A `cfg_div_m1` of 0 is treated as 1, so R ranges from 2 to 16. Each period starts with a low phase of ceil(R/2) cycles and ends with a high phase of floor(R/2) cycles.
- R3: In the cycle after acceptance, `mem_ce_n`, `mem_oe_n` and `mem_adv_n` go low. `mem_adv_n` stays low for exactly R system cycles, which is one memory clock period. `mem_addr` equals the accepted address and holds steady for that whole time.
- R4: Memory clock rising edges are numbered from 1, where edge 1 is the one that latches the address. The first word is taken at edge 1+LAT, with LAT = `cfg_lat_m2` + 2 (2 to 17). `mem_wait` is ignored on edges 1 to LAT.
- R5: In the data phase, a rising edge at which `mem_wait` is high captures nothing and does not advance the word count. The next edge without wait takes the same word.
- R6: `mem_rdata` is sampled at the system clock edge on which `mem_clk` rises. `rd_valid` is high for one cycle in the following cycle, with the sampled word on `rd_data`.
- R7: A burst delivers exactly `req_len_m1` + 1 words, in memory order.
- R8: The cycle after the last word is taken, `mem_ce_n` and `mem_oe_n` are high, `mem_clk` stays low, and `req_ready` is high again. In that same cycle `done` pulses for one cycle, together with the last `rd_valid`.
- R9: After reset, `mem_clk`, `rd_valid` and `done` are low; `mem_ce_n`, `mem_oe_n` and `mem_adv_n` are high; `req_ready` is high.
- R10: `mem_clk` is low whenever the memory is not selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_addr | input | ADDR_W (26) | Start word address |
| req_len_m1 | input | LEN_W (8) | Words in burst minus one |
| cfg_div_m1 | input | DIV_W (4) | Divide ratio minus one (0 acts as 1) |
| cfg_lat_m2 | input | LAT_W (4) | First-data latency minus two, in memory clocks |
| mem_clk | output | 1 | Memory clock |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | ADDR_W (26) | Address to memory |
| mem_rdata | input | DATA_W (16) | Read data from memory |
| mem_wait | input | 1 | Memory not ready, active high |
| rd_valid | output | 1 | Captured word valid, one cycle per word |
| rd_data | output | DATA_W (16) | Captured word |
| done | output | 1 | One-cycle pulse at burst end |

## Verification
The bench models a memory that shows a garbage value on every edge that should not be captured, including latency edges and wait edges. Any design that samples on the wrong edge, counts latency wrongly, or treats a wait during latency as a stall therefore returns wrong words or words in the wrong order.

The bench drives wait patterns that hit both the latency window and the data phase. A design that advanced its word count on a wait edge would skip a word and finish early.

Clock phase lengths are measured at odd ratios, at the smallest ratio, and with a divide setting of 0. A wrong rounding of the low phase, or a missing clamp, shows up as a wrong high or low run length.

Single-word bursts and the longest latency check that the end-of-burst clock park and the done pulse coincide with the final word.

// File: rtl/nbr_pkg.sv
// Package: shared types of the NOR burst read engine.
// Assumes: nothing beyond IEEE 1800-2017.
package nbr_pkg;

    // Sequencer phase of a burst.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LAT  = 2'd1,
        ST_DATA = 2'd2
    } nbr_state_e;

endpackage

// File: rtl/nbr_clkgen.sv
// Module: nbr_clkgen
// Builds the memory clock from the system clock. The period is R cycles.
// The low phase of ceil(R/2) cycles comes first, then the high phase of
// floor(R/2) cycles. It flags the cycle before each rising edge
// (rise_evt) and the last cycle of each period (wrap_evt).
// Assumes: start and stop are one-cycle pulses, and stop wins over start.
module nbr_clkgen #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic [DIV_W-1:0] div_m1,
    output logic             mem_clk,
    output logic             rise_evt,
    output logic             wrap_evt
);
    localparam int CW = DIV_W + 1;

    logic [DIV_W-1:0] rat_m1;
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] cnt_nxt;
    logic [CW-1:0]    low_len;
    logic             run;

    // Length of the low phase: ceil(R/2) = (rat_m1 + 2) / 2.
    assign low_len  = (CW'(rat_m1) + CW'(2)) >> 1;
    assign rise_evt = run && (CW'(cnt) == (low_len - CW'(1)));
    assign wrap_evt = run && (cnt == rat_m1);

    // Next phase count, wrapping at the end of the period.
    always_comb begin
        cnt_nxt = wrap_evt ? '0 : cnt + DIV_W'(1);
    end

    // Phase counter and clock register; ratio is latched at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rat_m1  <= DIV_W'(1);
            cnt     <= '0;
            run     <= 1'b0;
            mem_clk <= 1'b0;
        end else if (stop) begin
            cnt     <= '0;
            run     <= 1'b0;
            mem_clk <= 1'b0;
        end else if (start) begin
            rat_m1  <= (div_m1 == '0) ? DIV_W'(1) : div_m1;
            cnt     <= '0;
            run     <= 1'b1;
            mem_clk <= 1'b0;
        end else if (run) begin
            cnt     <= cnt_nxt;
            mem_clk <= (CW'(cnt_nxt) >= low_len);
        end
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= rat_m1));

    // R10
    idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !mem_clk);

    // R2
    rise_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_evt && !stop) |=> mem_clk);

endmodule

// File: rtl/nbr_seq.sv
// Module: nbr_seq
// Burst sequencer. It accepts requests, drives the strobes, counts the
// latency in memory clock rising edges, and counts the burst words. Data
// phase edges that see the wait input high are skipped.
// Assumes: rise_evt and wrap_evt come from nbr_clkgen for the running burst.
module nbr_seq
    import nbr_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [LEN_W-1:0] req_len_m1,
    input  logic [LAT_W-1:0] cfg_lat_m2,
    input  logic             rise_evt,
    input  logic             wrap_evt,
    input  logic             mem_wait,
    output logic             req_ready,
    output logic             accept,
    output logic             capture,
    output logic             stop,
    output logic             adv_n,
    output logic             ce_n,
    output logic             oe_n,
    output logic             done
);
    localparam int LCW = LAT_W + 1;

    nbr_state_e       state;
    logic [LCW-1:0]   lat_rem;
    logic [LEN_W-1:0] words_rem;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign capture   = (state == ST_DATA) && rise_evt && !mem_wait;
    assign stop      = capture && (words_rem == '0);

    // Burst phase, counters and memory strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            lat_rem   <= '0;
            words_rem <= '0;
            adv_n     <= 1'b1;
            ce_n      <= 1'b1;
            oe_n      <= 1'b1;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        lat_rem   <= LCW'(cfg_lat_m2) + LCW'(2);
                        words_rem <= req_len_m1;
                        adv_n     <= 1'b0;
                        ce_n      <= 1'b0;
                        oe_n      <= 1'b0;
                        state     <= ST_LAT;
                    end
                end
                ST_LAT: begin
                    if (wrap_evt) begin
                        adv_n <= 1'b1;
                    end
                    if (rise_evt) begin
                        lat_rem <= lat_rem - LCW'(1);
                        if (lat_rem == LCW'(1)) begin
                            state <= ST_DATA;
                        end
                    end
                end
                ST_DATA: begin
                    if (capture) begin
                        if (stop) begin
                            state <= ST_IDLE;
                            ce_n  <= 1'b1;
                            oe_n  <= 1'b1;
                            done  <= 1'b1;
                        end else begin
                            words_rem <= words_rem - LEN_W'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3
    adv_inside_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_n |-> !ce_n);

    // R4
    lat_spent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> (lat_rem == '0));

    // R5
    wait_holds_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_DATA) && rise_evt && mem_wait)
        |=> ((state == ST_DATA) && $stable(words_rem)));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/nbr_capture.sv
// Module: nbr_capture
// Registers the memory data word on each capture strobe and raises the
// data-valid output for exactly one cycle per captured word.
// Assumes: capture is high for at most one cycle per memory clock.
module nbr_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    // Sample the memory bus on each capture and flag the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= capture;
            if (capture) begin
                rd_data <= mem_rdata;
            end
        end
    end

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !capture) |=> !rd_valid);

endmodule

// File: rtl/nor_burst_reader.sv
// Module: nor_burst_reader (top)
// Synchronous burst read engine for an external NOR flash. It ties the
// clock generator, the sequencer and the data capture together, and holds
// the address register.
// Assumes: the memory changes data and wait only while mem_clk is low.
module nor_burst_reader #(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 16,
    parameter int LEN_W  = 8,
    parameter int DIV_W  = 4,
    parameter int LAT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len_m1,
    input  logic [DIV_W-1:0]  cfg_div_m1,
    input  logic [LAT_W-1:0]  cfg_lat_m2,
    output logic              mem_clk,
    output logic              mem_adv_n,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_wait,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);

    logic accept;
    logic capture;
    logic stop;
    logic rise_evt;
    logic wrap_evt;

    nbr_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .stop     (stop),
        .div_m1   (cfg_div_m1),
        .mem_clk  (mem_clk),
        .rise_evt (rise_evt),
        .wrap_evt (wrap_evt)
    );

    nbr_seq #(.LEN_W(LEN_W), .LAT_W(LAT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_len_m1 (req_len_m1),
        .cfg_lat_m2 (cfg_lat_m2),
        .rise_evt   (rise_evt),
        .wrap_evt   (wrap_evt),
        .mem_wait   (mem_wait),
        .req_ready  (req_ready),
        .accept     (accept),
        .capture    (capture),
        .stop       (stop),
        .adv_n      (mem_adv_n),
        .ce_n       (mem_ce_n),
        .oe_n       (mem_oe_n),
        .done       (done)
    );

    nbr_capture #(.DATA_W(DATA_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .mem_rdata (mem_rdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    // Address register, loaded once per accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
        end
    end

    // R3
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_adv_n && !$past(mem_adv_n)) |-> $stable(mem_addr));

    // R8
    end_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mem_ce_n && mem_oe_n && !mem_clk && rd_valid));

    // R6
    valid_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !done) |-> mem_clk);

    // R10
    deselect_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> !mem_clk);

endmodule

// File: tb/tb_nor_burst_reader.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task queues expected words, a memory model
// answers on mem_clk, and a monitor pops and compares each rd_valid word.
module tb_nor_burst_reader;
    localparam int ADDR_W = 26;
    localparam int DATA_W = 16;
    localparam int LEN_W  = 8;
    localparam int DIV_W  = 4;
    localparam int LAT_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len_m1 = '0;
    logic [DIV_W-1:0]  cfg_div_m1 = '0;
    logic [LAT_W-1:0]  cfg_lat_m2 = '0;
    logic              mem_clk, mem_adv_n, mem_ce_n, mem_oe_n;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              mem_wait = 1'b0;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic              done;

    nor_burst_reader dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len_m1(req_len_m1), .cfg_div_m1(cfg_div_m1),
        .cfg_lat_m2(cfg_lat_m2), .mem_clk(mem_clk), .mem_adv_n(mem_adv_n),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_wait(mem_wait), .rd_valid(rd_valid),
        .rd_data(rd_data), .done(done)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Memory model state
    int                m_lat = 2;
    int                m_mode = 0;
    int                m_edge = 0;
    int                m_wptr = 0;
    logic [ADDR_W-1:0] m_base = '0;
    int                cur_r = 2;
    logic [DATA_W-1:0] exp_q[$];
    bit                first_word = 1'b0;
    bit                done_seen = 1'b0;

    function automatic logic [DATA_W-1:0] word_of(logic [ADDR_W-1:0] a, int idx);
        return (a[15:0] + 16'(idx) * 16'h0111) ^ 16'h5A5A;
    endfunction

    function automatic bit wait_at(int e);
        if (m_mode == 1) return (e % 3) == 0;
        if (m_mode == 2) return (e <= m_lat) ? 1'b1 : ((e % 4) == 2);
        return 1'b0;
    endfunction

    // Present wait and data for the coming rising edge.
    task automatic drive_next();
        int e = m_edge + 1;
        mem_wait = wait_at(e);
        if (e >= 1 + m_lat && !mem_wait) mem_rdata = word_of(m_base, m_wptr);
        else mem_rdata = 16'hBAD0 ^ 16'(e);
    endtask

    always @(negedge mem_ce_n) begin
        m_edge = 0;
        m_wptr = 0;
        drive_next();
    end

    always @(posedge mem_clk) begin
        m_edge++;
        if (m_edge >= 1 + m_lat && !mem_wait) m_wptr++;
    end

    always @(negedge mem_clk) drive_next();

    // Scoreboard monitor and timing monitors.
    int adv_cnt = 0;
    bit addr_ok = 1'b1;
    int run_cnt = 0;
    bit prev_clk = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "word beyond burst length", rd_data, 0);
                end else begin
                    logic [DATA_W-1:0] e;
                    e = exp_q.pop_front();
                    if (first_word) check(rd_data == e, "R4", "first word", rd_data, e);
                    else if (m_mode != 0) check(rd_data == e, "R5", "word with waits", rd_data, e);
                    else check(rd_data == e, "R6", "burst word", rd_data, e);
                    first_word = 1'b0;
                end
            end
            if (done) begin
                check(exp_q.size() == 0, "R7", "words missing at done", exp_q.size(), 0);
                check(mem_ce_n && mem_oe_n && !mem_clk && req_ready, "R8", "parked at done",
                      {mem_ce_n, mem_oe_n, mem_clk, req_ready}, 4'b1101);
                check(rd_valid, "R8", "done with last word", rd_valid, 1);
                done_seen = 1'b1;
            end
            // address strobe length and address
            if (!mem_adv_n) begin
                adv_cnt++;
                if (mem_addr != m_base) addr_ok = 1'b0;
            end else if (adv_cnt > 0) begin
                check(adv_cnt == cur_r, "R3", "adv low cycles", adv_cnt, cur_r);
                check(addr_ok, "R3", "address during adv", mem_addr, m_base);
                adv_cnt = 0;
                addr_ok = 1'b1;
            end
            // memory clock phase lengths
            if (mem_ce_n) begin
                run_cnt = 0;
                prev_clk = 1'b0;
            end else if (mem_clk == prev_clk) begin
                run_cnt++;
            end else begin
                if (prev_clk) check(run_cnt == cur_r / 2, "R2", "high phase", run_cnt, cur_r / 2);
                else check(run_cnt == (cur_r + 1) / 2, "R2", "low phase", run_cnt, (cur_r + 1) / 2);
                run_cnt = 1;
                prev_clk = mem_clk;
            end
        end
    end

    // Driver: queue expected words, issue the request, wait for done.
    task automatic run_burst(input logic [ADDR_W-1:0] addr, input int len_m1,
                             input int div_m1, input int lat_m2, input int mode);
        m_base = addr;
        m_lat = lat_m2 + 2;
        m_mode = mode;
        cur_r = (div_m1 == 0) ? 2 : div_m1 + 1;
        for (int i = 0; i <= len_m1; i++) exp_q.push_back(word_of(addr, i));
        first_word = 1'b1;
        done_seen = 1'b0;
        @(negedge clk);
        check(req_ready, "R1", "ready before request", req_ready, 1);
        req_addr = addr;
        req_len_m1 = LEN_W'(len_m1);
        cfg_div_m1 = DIV_W'(div_m1);
        cfg_lat_m2 = LAT_W'(lat_m2);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cfg_div_m1 = DIV_W'(div_m1 ^ 3);
        cfg_lat_m2 = LAT_W'(lat_m2 ^ 5);
        check(!req_ready && !mem_ce_n && !mem_oe_n, "R1", "busy after accept",
              {req_ready, mem_ce_n, mem_oe_n}, 0);
        while (!done_seen) @(posedge clk);
        repeat (3) @(negedge clk);
        check(!mem_clk && mem_ce_n, "R10", "clock low while idle", {mem_clk, mem_ce_n}, 1);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(!mem_clk && mem_ce_n && mem_oe_n && mem_adv_n && !rd_valid && !done && req_ready,
              "R9", "reset state",
              {mem_clk, mem_ce_n, mem_oe_n, mem_adv_n, rd_valid, done, req_ready}, 7'b0111001);
        run_burst(26'h0012340, 3, 1, 0, 0);    // R=2, LAT=2, 4 words
        run_burst(26'h1ABCDE0, 0, 0, 15, 0);   // clamp R=2, LAT=17, single word
        run_burst(26'h0200100, 7, 2, 3, 1);    // R=3, LAT=5, waits in data phase
        run_burst(26'h3FFFF00, 5, 15, 1, 2);   // R=16, LAT=3, waits in latency too
        run_burst(26'h0055AA0, 15, 4, 2, 1);   // R=5, LAT=4, 16 words
        run_burst(26'h2000007, 2, 6, 0, 2);    // R=7, LAT=2
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule